// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block works out how many elements a vector operation may cover, given how many vector register banks are switched on and how many integer and floating-point registers each element needs. Software writes a bank-enable word and a register-usage pair. The unit then recomputes the maximum vector length with a short sequential division, and it raises a valid flag once the new value is ready.

An application asks for a vector length through a request port. The unit answers with the granted length, which is the smaller of the request and the current maximum. If a request arrives while a recomputation is still running, the unit holds it and answers it once the new maximum is valid. If several requests arrive during that time, only the latest one is kept.

Top module: `vlcfg_unit`

## Requirements
- R1: A bank-enable write keeps only the low 8 bits of `bank_data` as the bank mask. Bits 8 and above have no effect on `max_len`.
- R2: The number of active banks is the count of set bits in the stored bank mask. A mask of zero gives `max_len` = 0.
- R3: When `int_use + fp_use` is 0 or 1, the uncapped maximum is REGS_PER_BANK times the active bank count.
- R4: When `int_use + fp_use` is 2 or more, the uncapped maximum is floor(REGS_PER_BANK / (int_use + fp_use - 1)) times the active bank count.
- R5: `max_len` never exceeds UT_LIMIT. Any larger result is replaced by UT_LIMIT.
- R6: A granted length equals the smaller of the requested length and `max_len`.
- R7: The cycle after any write, `max_valid` is low. It rises again once the new maximum is loaded. While `max_valid` is high and no write occurs, both `max_len` and `max_valid` hold their values.
- R8: A request made while `max_valid` is low, or in the same cycle as a write, is not answered until `max_valid` is high. It is then answered against the new maximum. The latest such request replaces earlier held ones.
- R9: After reset, `max_len` = 0, `max_valid` = 1, `grant_valid` = 0 and `grant_len` = 0.
- R10: Each answered request produces exactly one single-cycle `grant_valid` pulse. A granted length is only presented while `max_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_wr | input | 1 | Write strobe for the bank-enable word |
| bank_data | input | DATA_W | Bank-enable word; the low 8 bits are kept |
| use_wr | input | 1 | Write strobe for the register-usage pair |
| int_use | input | CNT_W | Integer registers used per element |
| fp_use | input | CNT_W | Floating-point registers used per element |
| req_valid | input | 1 | Vector length request strobe |
| req_len | input | REQ_W | Requested vector length |
| max_len | output | LEN_W | Current maximum vector length |
| max_valid | output | 1 | High when `max_len` reflects the latest writes |
| grant_valid | output | 1 | Single-cycle pulse with a granted length |
| grant_len | output | LEN_W | Granted vector length |

## Verification
The bench builds the unit with REGS_PER_BANK = 256 and UT_LIMIT = 1500. With these values, eight or six active banks with light register usage give 2048 or 1536 uncapped. Both exceed the limit, so the cap is reached under ordinary settings. The 6-bit usage fields let the divisor range from 1 up to 125, so both the bypass branch and truncating quotients as small as 2 can be checked. A 16-bit write word exercises the dropping of the upper mask bits.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

   typedef enum logic [0:0] {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;

endpackage

// File: rtl/vlcfg_popcnt.sv
module vlcfg_popcnt #(
   parameter int NBITS = 8,
   localparam int OUT_W = $clog2(NBITS + 1)
) (
   input  logic [NBITS-1:0] bits,
   output logic [OUT_W-1:0] count
);

   logic [OUT_W-1:0] psum [NBITS+1];

   assign psum[0] = '0;

   for (genvar g = 0; g < NBITS; g++) begin : g_add
      assign psum[g+1] = psum[g] + OUT_W'(bits[g]);
   end

   assign count = psum[NBITS];

endmodule

// File: rtl/vlcfg_divider.sv
module vlcfg_divider
   import vlcfg_pkg::*;
#(
   parameter int DIV_W = 9,
   parameter int DS_W  = 7,
   localparam int CNT_W = $clog2(DIV_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIV_W-1:0] dividend,
   input  logic [DS_W-1:0]  divisor,
   output logic [DIV_W-1:0] quotient,
   output logic             done
);

   div_state_e       state;
   logic [DS_W-1:0]  rem;
   logic [DS_W-1:0]  dsr;
   logic [CNT_W-1:0] cnt;
   logic [DS_W:0]    rem_sh;
   logic             take;
   logic [DS_W-1:0]  rem_nx;

   // One restoring step: shift in the next dividend bit, subtract when it fits.
   always_comb begin
      rem_sh = {rem, quotient[DIV_W-1]};
      take   = rem_sh >= {1'b0, dsr};
      rem_nx = take ? DS_W'(rem_sh - {1'b0, dsr}) : rem_sh[DS_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= DIV_IDLE;
         rem      <= '0;
         dsr      <= '0;
         cnt      <= '0;
         quotient <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            state    <= DIV_RUN;
            rem      <= '0;
            dsr      <= divisor;
            quotient <= dividend;
            cnt      <= CNT_W'(DIV_W);
         end else if (state == DIV_RUN) begin
            rem      <= rem_nx;
            quotient <= {quotient[DIV_W-2:0], take};
            cnt      <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               state <= DIV_IDLE;
               done  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit #(
   parameter int DATA_W        = 16,
   parameter int NBANKS        = 8,
   parameter int CNT_W         = 6,
   parameter int REQ_W         = 16,
   parameter int REGS_PER_BANK = 256,
   parameter int UT_LIMIT      = 2048,
   localparam int LEN_W        = $clog2(UT_LIMIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_wr,
   input  logic [DATA_W-1:0] bank_data,
   input  logic              use_wr,
   input  logic [CNT_W-1:0]  int_use,
   input  logic [CNT_W-1:0]  fp_use,
   input  logic              req_valid,
   input  logic [REQ_W-1:0]  req_len,
   output logic [LEN_W-1:0]  max_len,
   output logic              max_valid,
   output logic              grant_valid,
   output logic [LEN_W-1:0]  grant_len
);

   localparam int BCNT_W = $clog2(NBANKS + 1);
   localparam int DIV_W  = $clog2(REGS_PER_BANK + 1);
   localparam int DS_W   = CNT_W + 1;
   localparam int PROD_W = DIV_W + BCNT_W;
   localparam int CMP_W  = (REQ_W > LEN_W) ? REQ_W : LEN_W;
   localparam int FULL   = REGS_PER_BANK * NBANKS;

   if (NBANKS < 1 || NBANKS > DATA_W) begin : g_chk_banks
      $error("vlcfg_unit: NBANKS must be within 1..DATA_W");
   end
   if (REGS_PER_BANK < 2) begin : g_chk_rpb
      $error("vlcfg_unit: REGS_PER_BANK must be at least 2");
   end
   if (UT_LIMIT < 1) begin : g_chk_lim
      $error("vlcfg_unit: UT_LIMIT must be positive");
   end

   logic [NBANKS-1:0] bank_q;
   logic [CNT_W-1:0]  iu_q, fu_q;
   logic              start_q;
   logic              pend_q;
   logic [REQ_W-1:0]  pend_len;
   logic              wr_any;
   logic [DS_W-1:0]   total;
   logic [DS_W-1:0]   divisor;
   logic [DIV_W-1:0]  quo;
   logic              div_done;
   logic [BCNT_W-1:0] nbank;
   logic [PROD_W-1:0] prod;
   logic [LEN_W-1:0]  capped;
   logic              serve_ok;

   if (DATA_W > NBANKS) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bank_data[DATA_W-1:NBANKS];
   end

   assign wr_any   = bank_wr | use_wr;
   assign total    = DS_W'(iu_q) + DS_W'(fu_q);
   // With fewer than two registers in use the formula degenerates to a divide by one.
   assign divisor  = (total < DS_W'(2)) ? DS_W'(1) : DS_W'(total - DS_W'(1));
   assign serve_ok = max_valid & ~wr_any;

   vlcfg_popcnt #(.NBITS(NBANKS)) u_popcnt (
      .bits  (bank_q),
      .count (nbank)
   );

   vlcfg_divider #(.DIV_W(DIV_W), .DS_W(DS_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_q),
      .dividend (DIV_W'(REGS_PER_BANK)),
      .divisor  (divisor),
      .quotient (quo),
      .done     (div_done)
   );

   assign prod = PROD_W'(quo) * PROD_W'(nbank);

   if (UT_LIMIT >= FULL) begin : g_nocap
      assign capped = LEN_W'(prod);
   end else begin : g_cap
      assign capped = (prod > PROD_W'(UT_LIMIT)) ? LEN_W'(UT_LIMIT) : prod[LEN_W-1:0];
   end

   // Configuration capture and maximum length update.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q    <= '0;
         iu_q      <= '0;
         fu_q      <= '0;
         start_q   <= 1'b0;
         max_len   <= '0;
         max_valid <= 1'b1;
      end else begin
         start_q <= wr_any;
         if (bank_wr) bank_q <= bank_data[NBANKS-1:0];
         if (use_wr) begin
            iu_q <= int_use;
            fu_q <= fp_use;
         end
         if (wr_any) begin
            max_valid <= 1'b0;
         end else if (div_done && !start_q) begin
            max_len   <= capped;
            max_valid <= 1'b1;
         end
      end
   end

   // Request handling: answer at once when valid, otherwise hold the latest.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_len    <= '0;
         grant_valid <= 1'b0;
         grant_len   <= '0;
      end else begin
         grant_valid <= 1'b0;
         if (req_valid) begin
            if (serve_ok) begin
               pend_q      <= 1'b0;
               grant_valid <= 1'b1;
               grant_len   <= (CMP_W'(req_len) < CMP_W'(max_len)) ? LEN_W'(req_len) : max_len;
            end else begin
               pend_q   <= 1'b1;
               pend_len <= req_len;
            end
         end else if (pend_q && serve_ok) begin
            pend_q      <= 1'b0;
            grant_valid <= 1'b1;
            grant_len   <= (CMP_W'(pend_len) < CMP_W'(max_len)) ? LEN_W'(pend_len) : max_len;
         end
      end
   end

endmodule

// File: rtl/vlcfg_unit_chk.sv
module vlcfg_unit_chk #(
   parameter int UT_LIMIT = 2048,
   parameter int LEN_W    = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bank_wr,
   input logic             use_wr,
   input logic [LEN_W-1:0] max_len,
   input logic             max_valid,
   input logic             grant_valid,
   input logic [LEN_W-1:0] grant_len
);

   a_r7_write_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_wr || use_wr) |=> !max_valid);

   a_r7_max_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (max_valid && !bank_wr && !use_wr) |=> (max_valid && $stable(max_len)));

   a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
      max_len <= LEN_W'(UT_LIMIT));

   a_r6_grant_bound: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (grant_len <= max_len));

   a_r10_grant_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> max_valid);

endmodule

bind vlcfg_unit vlcfg_unit_chk #(.UT_LIMIT(UT_LIMIT), .LEN_W(LEN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bank_wr     (bank_wr),
   .use_wr      (use_wr),
   .max_len     (max_len),
   .max_valid   (max_valid),
   .grant_valid (grant_valid),
   .grant_len   (grant_len)
);

// File: tb/vlcfg_unit_tb.sv
module vlcfg_unit_tb;

   localparam int DATA_W = 16;
   localparam int NBANKS = 8;
   localparam int CNT_W  = 6;
   localparam int REQ_W  = 16;
   localparam int RPB    = 256;
   localparam int LIM    = 1500;
   localparam int LEN_W  = $clog2(LIM + 1);
   localparam int NVEC   = 8;

   localparam logic [15:0] T_BANK [NVEC] = '{16'hFF00, 16'h00FF, 16'h0005, 16'h0F0F,
                                             16'h0081, 16'h00FF, 16'h0010, 16'h00FE};
   localparam int T_IU  [NVEC] = '{0, 0, 1, 2, 3, 63, 0, 10};
   localparam int T_FU  [NVEC] = '{0, 0, 0, 1, 4, 63, 2, 7};
   localparam int T_REQ [NVEC] = '{100, 3000, 1000, 300, 84, 0, 65535, 111};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bank_wr = 1'b0;
   logic [DATA_W-1:0] bank_data = '0;
   logic              use_wr = 1'b0;
   logic [CNT_W-1:0]  int_use = '0;
   logic [CNT_W-1:0]  fp_use = '0;
   logic              req_valid = 1'b0;
   logic [REQ_W-1:0]  req_len = '0;
   logic [LEN_W-1:0]  max_len;
   logic              max_valid;
   logic              grant_valid;
   logic [LEN_W-1:0]  grant_len;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   vlcfg_unit #(.DATA_W(DATA_W), .NBANKS(NBANKS), .CNT_W(CNT_W), .REQ_W(REQ_W),
                .REGS_PER_BANK(RPB), .UT_LIMIT(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_data(bank_data),
      .use_wr(use_wr), .int_use(int_use), .fp_use(fp_use), .req_valid(req_valid),
      .req_len(req_len), .max_len(max_len), .max_valid(max_valid),
      .grant_valid(grant_valid), .grant_len(grant_len));

   function automatic int exp_max(input int bank, input int iu, input int fu);
      int nb = $countones(bank & 8'hFF);
      int t  = iu + fu;
      int q  = (t < 2) ? RPB : RPB / (t - 1);
      int m  = q * nb;
      return (m > LIM) ? LIM : m;
   endfunction

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wait_valid(output bit ok);
      ok = 1'b0;
      for (int k = 0; k < 60; k++) begin
         if (max_valid) begin ok = 1'b1; break; end
         tick();
      end
   endtask

   task automatic wait_grant(output bit ok);
      ok = 1'b0;
      for (int k = 0; k < 60; k++) begin
         if (grant_valid) begin ok = 1'b1; break; end
         tick();
      end
   endtask

   task automatic write_cfg(input int bank, input int iu, input int fu);
      bank_wr   = 1'b1;
      bank_data = DATA_W'(bank);
      use_wr    = 1'b1;
      int_use   = CNT_W'(iu);
      fp_use    = CNT_W'(fu);
      tick();
      bank_wr = 1'b0;
      use_wr  = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      bit ok;
      int em;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
      // R9: reset state
      check("R9 max_len", int'(max_len), 0);
      check("R9 max_valid", int'(max_valid), 1);
      check("R9 grant_valid", int'(grant_valid), 0);
      check("R9 grant_len", int'(grant_len), 0);

      // Table walk: R1..R6
      for (int v = 0; v < NVEC; v++) begin
         em = exp_max(int'(T_BANK[v]), T_IU[v], T_FU[v]);
         write_cfg(int'(T_BANK[v]), T_IU[v], T_FU[v]);
         check("R7 valid low after write", int'(max_valid), 0);
         wait_valid(ok);
         check("R7 valid returns", int'(ok), 1);
         check($sformatf("R1 R2 R3 R4 R5 max vec%0d", v), int'(max_len), em);
         req_valid = 1'b1;
         req_len   = REQ_W'(T_REQ[v]);
         tick();
         req_valid = 1'b0;
         check($sformatf("R6 immediate grant vec%0d", v), int'(grant_valid), 1);
         check($sformatf("R6 grant_len vec%0d", v), int'(grant_len), imin(em, T_REQ[v]));
         tick();
         check("R10 single pulse", int'(grant_valid), 0);
      end

      // R7: max holds while idle
      tick(); tick();
      check("R7 max holds", int'(max_len), exp_max(16'h00FE, 10, 7));

      // R8: requests during recompute, latest wins
      write_cfg(16'h00FF, 1, 1);
      req_valid = 1'b1; req_len = 16'd5000;
      tick();
      req_len = 16'd700;
      tick();
      req_valid = 1'b0;
      check("R8 no grant while busy", int'(grant_valid), 0);
      wait_grant(ok);
      check("R8 held request answered", int'(ok), 1);
      check("R8 answered with valid max", int'(max_valid), 1);
      check("R8 latest request wins", int'(grant_len), 700);
      check("R5 capped eight banks", int'(max_len), LIM);
      tick();
      check("R10 held grant single pulse", int'(grant_valid), 0);

      // R8: request in the same cycle as a write
      bank_wr = 1'b1; bank_data = 16'h3303; use_wr = 1'b1; int_use = '0; fp_use = '0;
      req_valid = 1'b1; req_len = 16'd900;
      tick();
      bank_wr = 1'b0; use_wr = 1'b0; req_valid = 1'b0;
      check("R8 same-cycle no early grant", int'(grant_valid), 0);
      wait_grant(ok);
      check("R8 same-cycle answered", int'(ok), 1);
      check("R8 R1 same-cycle uses new max", int'(grant_len), 512);

      // R2: six banks capped, R4 truncation corner
      write_cfg(16'h003F, 0, 1);
      wait_valid(ok);
      check("R5 six banks capped", int'(max_len), LIM);
      write_cfg(16'h0001, 2, 2);
      wait_valid(ok);
      check("R4 truncating quotient", int'(max_len), 85);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule